// File: doc/BRIEF.md
# Isochronous split-transaction descriptor sequencer

This block decides, once per descriptor visit, what a high-speed host does with one full-speed isochronous split descriptor in the current microframe. It is given the descriptor's start-split and complete-split masks, its Active flag, its split state and the microframe index. It answers with one-cycle commands: issue a start split, issue a complete split, visit the back-pointed previous descriptor, or advance to the next schedule item. Together with the advance command it hands back the updated split state and Active flag, to be written back into the descriptor.

At the start of a frame, a descriptor may first have to wait on the descriptor of the previous frame, reached through a back pointer. When that earlier descriptor is reported inactive, control comes back here and the split state is forced to the start phase. If microframe 0 is current and start-mask bit 0 is set, a start split goes out at once in the same return. This is the wrap-around case in which a start split lands in microframe 0.

Top module: `iso_split_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every command output, `cfg_err` and `wb_valid` are 0.
- R2: A visit is a one-cycle `visit_req`. Outputs respond in the next cycle. In the start phase (`state_in`=0), if start-mask bit `uframe` is set, `cmd_ss` is raised and the written-back state is 1 (complete phase). Otherwise no transaction is issued and the state stays 0.
- R3: In the complete phase (`state_in`=1) with `err_in`=0, if complete-mask bit `uframe` is set, `cmd_cs` is raised. When no higher complete-mask bit is set, the write-back carries Active=0 and state=0. Otherwise it carries Active=1 and state=1.
- R4: In the complete phase with `err_in`=1, no transaction is issued, and the write-back carries Active=0 and state=0.
- R5: Each visit ends with exactly one `cmd_next`, coincident with `wb_valid`. At most one of `cmd_ss` and `cmd_cs` is raised, and only in that same cycle.
- R6: A visit with `active_in`=0 yields only `cmd_next`. The write-back echoes the incoming state and Active=0.
- R7: An active descriptor with complete-mask bits 0 and 1 both set and start-mask bit 0 set raises `cfg_err` with `cmd_next`. No transaction is issued and the state is echoed.
- R8: An active, well-formed descriptor visited in microframe 0 or 1 with `bp_valid`=1 raises `cmd_bp` alone, with no `cmd_next`. The visit then waits for `bp_rsp`.
- R9: When `bp_rsp` arrives with `prev_active`=0, the next cycle gives `cmd_next`. If the visit's microframe was 0 and start-mask bit 0 is set, `cmd_ss` is raised with state 1. Otherwise no transaction is issued and state 0 is written back.
- R10: When `bp_rsp` arrives with `prev_active`=1, only `cmd_next` follows, echoing the visit's state and Active flag.
- R11: A `visit_req` that arrives while a back-pointer response is awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| visit_req | input | 1 | One-cycle start of a descriptor visit |
| ss_mask | input | 8 | Start-split mask, bit n = microframe n |
| cs_mask | input | 8 | Complete-split mask, bit n = microframe n |
| active_in | input | 1 | Descriptor Active flag |
| state_in | input | 1 | Split state: 0 start phase, 1 complete phase |
| uframe | input | 3 | Current microframe index |
| err_in | input | 1 | Transaction error detected for this descriptor |
| bp_valid | input | 1 | Back pointer present |
| bp_rsp | input | 1 | Back-pointed descriptor status available |
| prev_active | input | 1 | Active flag of the back-pointed descriptor |
| cmd_ss | output | 1 | Issue start split |
| cmd_cs | output | 1 | Issue complete split |
| cmd_bp | output | 1 | Visit back-pointed descriptor |
| cmd_next | output | 1 | Advance to next schedule item |
| cfg_err | output | 1 | Unsupported mask combination |
| wb_valid | output | 1 | Write-back fields valid |
| wb_state | output | 1 | Updated split state |
| wb_active | output | 1 | Updated Active flag |

## Verification
Two functions can fall in the same cycle. The back-pointer return can emit a start split together with the advance command, and a configuration error coincides with the advance. The bench provokes the first by visiting in microframe 0 with start-mask bit 0 set, then answering the back-pointer visit with an inactive previous descriptor. It judges that cycle by requiring `cmd_ss`, `cmd_next` and a complete-phase write-back together, while the same return in microframe 1 must give the advance alone. A visit request that collides with the wait for the back-pointer response is also driven, and must leave the outputs quiet.

// File: rtl/iso_split_seq.sv
module iso_split_seq #(
  parameter int UF = 8,
  localparam int UFW = $clog2(UF)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           visit_req,
  input  logic [UF-1:0]  ss_mask,
  input  logic [UF-1:0]  cs_mask,
  input  logic           active_in,
  input  logic           state_in,
  input  logic [UFW-1:0] uframe,
  input  logic           err_in,
  input  logic           bp_valid,
  input  logic           bp_rsp,
  input  logic           prev_active,
  output logic           cmd_ss,
  output logic           cmd_cs,
  output logic           cmd_bp,
  output logic           cmd_next,
  output logic           cfg_err,
  output logic           wb_valid,
  output logic           wb_state,
  output logic           wb_active
);

  logic           waiting;
  logic           st_q, act_q, wrap_q;

  wire ss_cur   = ss_mask[uframe];
  wire cs_cur   = cs_mask[uframe];
  wire cs_above = |(cs_mask >> ({1'b0, uframe} + 1'b1));
  wire bad_cfg  = cs_mask[0] & cs_mask[1] & ss_mask[0];
  wire bp_hit   = bp_valid & (uframe < 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      st_q      <= 1'b0;
      act_q     <= 1'b0;
      wrap_q    <= 1'b0;
      cmd_ss    <= 1'b0;
      cmd_cs    <= 1'b0;
      cmd_bp    <= 1'b0;
      cmd_next  <= 1'b0;
      cfg_err   <= 1'b0;
      wb_valid  <= 1'b0;
      wb_state  <= 1'b0;
      wb_active <= 1'b0;
    end else begin
      cmd_ss   <= 1'b0;
      cmd_cs   <= 1'b0;
      cmd_bp   <= 1'b0;
      cmd_next <= 1'b0;
      cfg_err  <= 1'b0;
      wb_valid <= 1'b0;
      if (waiting) begin
        if (bp_rsp) begin
          waiting   <= 1'b0;
          cmd_next  <= 1'b1;
          wb_valid  <= 1'b1;
          wb_active <= act_q;
          if (prev_active) begin
            wb_state <= st_q;
          end else if (wrap_q) begin
            cmd_ss   <= 1'b1;
            wb_state <= 1'b1;
          end else begin
            wb_state <= 1'b0;
          end
        end
      end else if (visit_req) begin
        st_q   <= state_in;
        act_q  <= active_in;
        wrap_q <= (uframe == '0) & ss_mask[0];
        if (!active_in || bad_cfg || !bp_hit) begin
          cmd_next  <= 1'b1;
          wb_valid  <= 1'b1;
          wb_state  <= state_in;
          wb_active <= active_in;
        end
        if (!active_in) begin
        end else if (bad_cfg) begin
          cfg_err <= 1'b1;
        end else if (bp_hit) begin
          cmd_bp  <= 1'b1;
          waiting <= 1'b1;
        end else if (!state_in) begin
          if (ss_cur) begin
            cmd_ss   <= 1'b1;
            wb_state <= 1'b1;
          end
        end else if (err_in) begin
          wb_state  <= 1'b0;
          wb_active <= 1'b0;
        end else if (cs_cur) begin
          cmd_cs <= 1'b1;
          if (!cs_above) begin
            wb_state  <= 1'b0;
            wb_active <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/iso_split_seq_chk.sv
module iso_split_seq_chk #(
  parameter int UF = 8,
  localparam int UFW = $clog2(UF)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           visit_req,
  input logic [UF-1:0]  ss_mask,
  input logic [UF-1:0]  cs_mask,
  input logic           active_in,
  input logic           state_in,
  input logic [UFW-1:0] uframe,
  input logic           err_in,
  input logic           bp_valid,
  input logic           bp_rsp,
  input logic           prev_active,
  input logic           cmd_ss,
  input logic           cmd_cs,
  input logic           cmd_bp,
  input logic           cmd_next,
  input logic           cfg_err,
  input logic           wb_valid,
  input logic           wb_state,
  input logic           wb_active
);

  assert_single_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ss && cmd_cs));

  assert_txn_with_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ss || cmd_cs) |-> (cmd_next && wb_valid));

  assert_next_has_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_next |-> wb_valid);

  assert_ss_to_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ss |-> wb_state);

  assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cmd_next && !cmd_ss && !cmd_cs && !cmd_bp));

  assert_bp_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bp |-> (!cmd_next && !cmd_ss && !cmd_cs && !cfg_err));

  assert_bp_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bp |-> ($past(bp_valid) && ($past(uframe) < 2)));

  assert_cs_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs |-> !$past(err_in));

endmodule

bind iso_split_seq iso_split_seq_chk #(.UF(UF)) u_chk (.*);

// File: tb/tb_iso_split_seq.sv
module tb_iso_split_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       visit_req = 1'b0;
  logic [7:0] ss_mask = '0, cs_mask = '0;
  logic       active_in = 1'b0, state_in = 1'b0;
  logic [2:0] uframe = '0;
  logic       err_in = 1'b0, bp_valid = 1'b0, bp_rsp = 1'b0, prev_active = 1'b0;
  logic       cmd_ss, cmd_cs, cmd_bp, cmd_next, cfg_err, wb_valid, wb_state, wb_active;
  int         vectors = 0, errors = 0;

  always #10 clk = ~clk;

  iso_split_seq dut (.*);

  task automatic check(string req, logic [4:0] cmd_exp, logic [1:0] wb_exp);
    logic [4:0] cmd_got;
    cmd_got = {cmd_ss, cmd_cs, cmd_bp, cmd_next, cfg_err};
    vectors++;
    if (cmd_got !== cmd_exp || wb_valid !== cmd_exp[1] ||
        (cmd_exp[1] && {wb_state, wb_active} !== wb_exp)) begin
      errors++;
      $display("FAIL %s: cmd(ss,cs,bp,next,cfg)=%b wb_v=%b wb(st,act)=%b%b expected cmd=%b wb=%b",
               req, cmd_got, wb_valid, wb_state, wb_active, cmd_exp, wb_exp);
    end
  endtask

  task automatic visit(logic [7:0] ss, logic [7:0] cs, logic act, logic st,
                       logic [2:0] uf, logic err, logic bpv);
    @(negedge clk);
    ss_mask = ss; cs_mask = cs; active_in = act; state_in = st;
    uframe = uf; err_in = err; bp_valid = bpv; visit_req = 1'b1;
    @(negedge clk);
    visit_req = 1'b0; err_in = 1'b0; bp_valid = 1'b0;
  endtask

  task automatic bp_return(logic pa);
    @(negedge clk);
    bp_rsp = 1'b1; prev_active = pa;
    @(negedge clk);
    bp_rsp = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", 5'b00000, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", 5'b00000, 2'b00);
  endtask

  task automatic t_start;
    visit(8'h04, 8'h00, 1, 0, 3'd2, 0, 0); check("R2 hit", 5'b10010, 2'b11);
    visit(8'h04, 8'h00, 1, 0, 3'd3, 0, 0); check("R2 miss", 5'b00010, 2'b01);
  endtask

  task automatic t_complete;
    visit(8'h04, 8'h3C, 1, 1, 3'd3, 0, 0); check("R3 mid", 5'b01010, 2'b11);
    visit(8'h04, 8'h3C, 1, 1, 3'd5, 0, 0); check("R3 last", 5'b01010, 2'b00);
    visit(8'h04, 8'h3C, 1, 1, 3'd6, 0, 0); check("R3 miss", 5'b00010, 2'b11);
    visit(8'h04, 8'h3C, 1, 1, 3'd4, 1, 0); check("R4 err", 5'b00010, 2'b00);
  endtask

  task automatic t_inactive_cfg;
    visit(8'h04, 8'h3C, 0, 1, 3'd4, 0, 0); check("R6", 5'b00010, 2'b10);
    visit(8'h01, 8'h03, 1, 0, 3'd0, 0, 1); check("R7", 5'b00011, 2'b01);
  endtask

  task automatic t_wrap;
    visit(8'h01, 8'h1C, 1, 1, 3'd0, 0, 1); check("R8 req", 5'b00100, 2'b00);
    bp_return(1'b0);                       check("R9 wrap", 5'b10010, 2'b11);
    visit(8'h01, 8'h1C, 1, 1, 3'd1, 0, 1); check("R8 uf1", 5'b00100, 2'b00);
    bp_return(1'b0);                       check("R9 nowrap", 5'b00010, 2'b01);
  endtask

  task automatic t_prev_active;
    visit(8'h01, 8'h1C, 1, 1, 3'd0, 0, 1); check("R8 req", 5'b00100, 2'b00);
    visit(8'h02, 8'h00, 1, 0, 3'd1, 0, 0); check("R11", 5'b00000, 2'b00);
    bp_return(1'b1);                       check("R10", 5'b00010, 2'b11);
    visit(8'h01, 8'h00, 1, 0, 3'd0, 0, 0); check("R8 no bp", 5'b10010, 2'b11);
  endtask

  initial begin
    t_reset();
    t_start();
    t_complete();
    t_inactive_cfg();
    t_wrap();
    t_prev_active();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule